// File: doc/BRIEF.md
# Receive FIFO Read Port

This block is the software-visible read side of a serial controller's receive queue. A small synchronous FIFO is filled by the receive datapath through a push strobe. A 32-bit register read interface drains it. A normal read of the data register, at byte offset 0x340, returns the oldest frame and pops it in the same access. A read flagged as coming from a debugger returns the same frame but leaves the queue as it is.

The block covers the edge cases around these reads:

- A read while the controller is disabled returns all ones.
- A read of an empty queue returns all ones.
- Returned frames are cut to the configured memory width, and the unused upper bits read as zero.
- A normal read of an empty queue raises a sticky underflow flag.
- A push into a full queue is dropped and raises a sticky overflow flag.
- Writes to the register are ignored.

Read data is registered and appears one clock after the read strobe.

Top module: `rxq_read_port`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0, both interrupt flags are 0 and `reg_rdata` is 0.
- R2: Each accepted push appends `push_data` to the queue. Frames leave in arrival order. `fifo_full` is 1 when 8 frames are held. `fifo_empty` is 1 when no frame is held.
- R3: A push while the queue holds 8 frames, with no pop in the same cycle, is dropped and sets `irq_overflow`. The flag stays 1 until `clr_overflow` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R4: An enabled, non-debug read (`reg_rd`=1, `reg_wr`=0, `reg_addr`=0x340) of a non-empty queue returns the oldest frame on `reg_rdata` in the next cycle and removes that frame.
- R5: Returned frames are masked by `mem_width`. Value 0 keeps bits 7:0. Value 1 keeps bits 15:0. Values 2 and 3 keep all 32 bits. Bits that are not kept read as 0.
- R6: A read at 0x340 while `enable` is 0 returns 0xFFFFFFFF, pops nothing and does not set `irq_underflow`.
- R7: An enabled read at 0x340 of an empty queue returns 0xFFFFFFFF. If the read is non-debug, it also sets `irq_underflow`. The flag stays 1 until `clr_underflow` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: A read with `reg_dbg`=1 returns the same value a normal read would, but never pops and never sets `irq_underflow`.
- R9: A cycle with `reg_wr`=1 changes neither the queue, the flags nor `reg_rdata`, even when `reg_rd` is also 1.
- R10: A read at any other offset returns 0 and leaves the queue unchanged.
- R11: A push and a pop in the same cycle both take effect, including when the queue is full. The frame count is then unchanged and no overflow is raised.
- R12: `reg_rdata` holds its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; reads return all ones when 0 |
| mem_width | input | 2 | Frame width select: 0 = 8 bit, 1 = 16 bit, 2/3 = 32 bit |
| push_valid | input | 1 | Receive datapath push strobe |
| push_data | input | 32 | Frame to push |
| fifo_full | output | 1 | Queue holds 8 frames |
| fifo_empty | output | 1 | Queue holds no frame |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe (ignored) |
| reg_dbg | input | 1 | Access comes from a debugger |
| reg_rdata | output | 32 | Registered read data |
| clr_underflow | input | 1 | Clear pulse for the underflow flag |
| clr_overflow | input | 1 | Clear pulse for the overflow flag |
| irq_underflow | output | 1 | Sticky underflow flag |
| irq_overflow | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall in the same cycle and interact: a push from the receive side and a pop from a register read. The hard case is a full queue, where the order of the two decides whether the frame is dropped. Directed steps fill the queue to 8 and then push and read in one cycle. Random traffic also hits this case whenever it occurs. After each edge, the bench compares `fifo_full`, `irq_overflow` and the sequence of frames later read against a queue model that pops before it pushes. The same approach covers flag set and clear pulses that land in one cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned FRAME_W = 32;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32B = 2'd3
  } width_e;

  // Keep only the bits selected by the width control; the rest become 0.
  function automatic logic [FRAME_W-1:0] frame_mask(
    input logic [FRAME_W-1:0] d,
    input logic [1:0]         w
  );
    logic [FRAME_W-1:0] r;
    r = d;
    case (width_e'(w))
      WID_8:   r = {{(FRAME_W-8){1'b0}},  d[7:0]};
      WID_16:  r = {{(FRAME_W-16){1'b0}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

  // Value returned when there is nothing valid to read.
  function automatic logic [FRAME_W-1:0] no_data_word();
    return {FRAME_W{1'b1}};
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty,
  output logic         push_drop
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_acc;
  logic             pop_acc;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign pop_acc   = pop & ~empty;
  assign push_acc  = push & (~full | pop_acc);
  assign push_drop = push & full & ~pop_acc;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_next(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_acc, pop_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> $stable(count));

  assert_swap_keeps_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(count));

endmodule

// File: rtl/rxq_read_ctrl.sv
module rxq_read_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] RD_OFFSET = 12'h340
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         mem_width,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic               reg_dbg,
  input  logic               fifo_empty,
  input  logic [FRAME_W-1:0] head,
  output logic               pop,
  output logic               underflow_evt,
  output logic [FRAME_W-1:0] reg_rdata
);
  logic               rd_cycle;
  logic               rd_hit;
  logic               no_data;
  logic [FRAME_W-1:0] rd_value;

  // A write strobe wins over a read strobe: the whole access is ignored.
  assign rd_cycle      = reg_rd & ~reg_wr;
  assign rd_hit        = rd_cycle & (reg_addr == RD_OFFSET);
  assign no_data       = ~enable | fifo_empty;
  assign pop           = rd_hit & enable & ~fifo_empty & ~reg_dbg;
  assign underflow_evt = rd_hit & enable & fifo_empty & ~reg_dbg;

  always_comb begin
    if (!rd_hit)      rd_value = '0;
    else if (no_data) rd_value = no_data_word();
    else              rd_value = frame_mask(head, mem_width);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata <= '0;
    else if (rd_cycle) reg_rdata <= rd_value;
  end

  assert_empty_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && no_data) |=> (reg_rdata == {FRAME_W{1'b1}}));

  assert_debug_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_dbg |-> (!pop && !underflow_evt));

  assert_disabled_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!pop && !underflow_evt));

  assert_write_holds_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> $stable(reg_rdata));

endmodule

// File: rtl/rxq_sticky_flags.sv
module rxq_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port
  import rxq_pkg::*;
#(
  parameter int unsigned       DEPTH     = 8,
  parameter int unsigned       ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] RD_OFFSET = 12'h340
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         mem_width,
  input  logic               push_valid,
  input  logic [FRAME_W-1:0] push_data,
  output logic               fifo_full,
  output logic               fifo_empty,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic               reg_dbg,
  output logic [FRAME_W-1:0] reg_rdata,
  input  logic               clr_underflow,
  input  logic               clr_overflow,
  output logic               irq_underflow,
  output logic               irq_overflow
);
  localparam int unsigned FLAG_UF = 0;
  localparam int unsigned FLAG_OF = 1;
  localparam int unsigned N_FLAGS = 2;

  logic               pop_evt;
  logic               underflow_evt;
  logic               push_drop_evt;
  logic [FRAME_W-1:0] head;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

  rxq_fifo #(.DEPTH(DEPTH), .W(FRAME_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (pop_evt),
    .head      (head),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .push_drop (push_drop_evt)
  );

  rxq_read_ctrl #(.ADDR_W(ADDR_W), .RD_OFFSET(RD_OFFSET)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .mem_width     (mem_width),
    .reg_addr      (reg_addr),
    .reg_rd        (reg_rd),
    .reg_wr        (reg_wr),
    .reg_dbg       (reg_dbg),
    .fifo_empty    (fifo_empty),
    .head          (head),
    .pop           (pop_evt),
    .underflow_evt (underflow_evt),
    .reg_rdata     (reg_rdata)
  );

  assign flag_set[FLAG_UF] = underflow_evt;
  assign flag_set[FLAG_OF] = push_drop_evt;
  assign flag_clr[FLAG_UF] = clr_underflow;
  assign flag_clr[FLAG_OF] = clr_overflow;

  rxq_sticky_flags #(.N(N_FLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  assign irq_underflow = flag_q[FLAG_UF];
  assign irq_overflow  = flag_q[FLAG_OF];

  assert_pop_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> !fifo_empty);

  assert_drop_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop_evt |-> (fifo_full && !pop_evt));

  assert_underflow_only_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |-> fifo_empty);

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

endmodule

// File: tb/rxq_read_port_test.sv
module rxq_read_port_test;
  localparam logic [11:0] OFS = 12'h340;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mem_width = 2'd2;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        fifo_full, fifo_empty;
  logic [11:0] reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_dbg = 1'b0;
  logic [31:0] reg_rdata;
  logic        clr_underflow = 1'b0, clr_overflow = 1'b0;
  logic        irq_underflow, irq_overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] q[$];
  logic        m_uf = 1'b0, m_of = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  rxq_read_port uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mem_width(mem_width),
    .push_valid(push_valid), .push_data(push_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_dbg(reg_dbg),
    .reg_rdata(reg_rdata), .clr_underflow(clr_underflow), .clr_overflow(clr_overflow),
    .irq_underflow(irq_underflow), .irq_overflow(irq_overflow)
  );

  function automatic logic [31:0] exp_mask(input logic [31:0] d, input logic [1:0] w);
    logic [31:0] keep;
    keep = (w == 2'd0) ? 32'h0000_00FF : (w == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return d & keep;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, update the model, compare at the next falling edge.
  task automatic step(input bit push, input logic [31:0] pd, input bit rd, input bit wr,
                      input bit dbg, input logic [11:0] addr, input bit cu, input bit co,
                      input string tag);
    bit hit, pop, was_full, empty0;
    push_valid = push; push_data = pd; reg_rd = rd; reg_wr = wr; reg_dbg = dbg;
    reg_addr = addr; clr_underflow = cu; clr_overflow = co;
    empty0   = (q.size() == 0);
    was_full = (q.size() == 8);
    hit = rd && !wr && (addr == OFS);
    pop = hit && enable && !dbg && !empty0;
    if (rd && !wr) begin
      if (!hit)                m_rdata = 32'h0;
      else if (!enable || empty0) m_rdata = 32'hFFFF_FFFF;
      else                     m_rdata = exp_mask(q[0], mem_width);
    end
    if (hit && enable && !dbg && empty0) m_uf = 1'b1;
    else if (cu)                         m_uf = 1'b0;
    if (push && was_full && !pop) m_of = 1'b1;
    else if (co)                  m_of = 1'b0;
    if (pop) void'(q.pop_front());
    if (push && (!was_full || pop)) q.push_back(pd);
    @(negedge clk);
    chk(tag, "rdata", reg_rdata, m_rdata);
    chk(tag, "empty", {31'd0, fifo_empty}, {31'd0, q.size() == 0});
    chk(tag, "full", {31'd0, fifo_full}, {31'd0, q.size() == 8});
    chk(tag, "uf", {31'd0, irq_underflow}, {31'd0, m_uf});
    chk(tag, "of", {31'd0, irq_overflow}, {31'd0, m_of});
    push_valid = 0; reg_rd = 0; reg_wr = 0; reg_dbg = 0; clr_underflow = 0; clr_overflow = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rdata", reg_rdata, 32'h0);
    chk("R1", "empty", {31'd0, fifo_empty}, 32'd1);
    chk("R1", "full", {31'd0, fifo_full}, 32'd0);
    chk("R1", "flags", {30'd0, irq_underflow, irq_overflow}, 32'd0);

    enable = 1'b1; mem_width = 2'd2;
    step(0, 0, 1, 0, 0, OFS, 0, 0, "R7");       // empty read: ones, underflow set
    step(0, 0, 0, 0, 0, OFS, 0, 0, "R12");      // hold
    step(0, 0, 0, 0, 0, OFS, 1, 0, "R7");       // clear
    step(0, 0, 1, 0, 0, OFS, 1, 0, "R7");       // set wins over clear
    step(0, 0, 0, 0, 0, OFS, 1, 0, "R7");
    step(0, 0, 1, 0, 1, OFS, 0, 0, "R8");       // debug empty read: no underflow
    for (int i = 0; i < 8; i++) step(1, 32'hA5C3_0000 + 32'(i * 32'h1111), 0, 0, 0, OFS, 0, 0, "R2");
    step(1, 32'hDEAD_BEEF, 0, 0, 0, OFS, 0, 0, "R3");   // dropped
    step(1, 32'hDEAD_BEEF, 0, 0, 0, OFS, 0, 1, "R3");   // set wins over clear
    step(0, 0, 0, 0, 0, OFS, 0, 1, "R3");
    step(0, 0, 1, 0, 1, OFS, 0, 0, "R8");       // debug read keeps full
    step(0, 0, 1, 1, 0, OFS, 0, 0, "R9");       // read+write ignored
    step(0, 0, 0, 1, 0, OFS, 0, 0, "R9");
    step(0, 0, 1, 0, 0, 12'h344, 0, 0, "R10");
    step(1, 32'h1234_5678, 1, 0, 0, OFS, 0, 0, "R11"); // full: push and pop together
    mem_width = 2'd0; step(0, 0, 1, 0, 0, OFS, 0, 0, "R5");
    mem_width = 2'd1; step(0, 0, 1, 0, 0, OFS, 0, 0, "R5");
    mem_width = 2'd3; step(0, 0, 1, 0, 0, OFS, 0, 0, "R5");
    enable = 1'b0;    step(0, 0, 1, 0, 0, OFS, 0, 0, "R6");
    enable = 1'b1;
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 0, OFS, 0, 0, "R4");
    step(0, 0, 1, 0, 0, OFS, 0, 0, "R7");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      enable    = (r[3:0] != 4'd0);
      mem_width = r[5:4];
      step(r[6] | r[7], $urandom, r[8] | r[9], (r[12:10] == 3'd0), (r[15:13] == 3'd0),
           (r[18:16] == 3'd0) ? 12'h33C : OFS, (r[21:19] == 3'd0), (r[24:22] == 3'd0), "R11");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule